// File: doc/BRIEF.md
# System Call Entry and Return Controller

This block decides what happens when a 64-bit core executes a system call or a system-call return. For a call it picks one of three outcomes. The first is the legacy call. The second is the vectored call, which has 128 entry points. The third is a facility-unavailable exception, raised when a vectored call is attempted from user mode while the facility is switched off. It then produces the outputs for that outcome, all registered:

- the 17-bit interrupt vector and the 64-bit fetch address;
- the selector for the register pair that receives the return state;
- the write enables for both banks of the two-bank save-register RAM;
- set and clear masks for the machine state word.

For a return it names the register pair to read and turns the saved state bits into the four mode bits used for the redirect.

The facility enable bit is held inside the block. It resets to 1 and is changed through a one-bit write port. The caller decodes the instruction and presents instruction bit 1 and instruction bits 11:5, together with the current user-mode bit and, for returns, four bits of the saved state word. When `valid_i` is low the block does nothing.

Top module: `syscall_ctl`

## Requirements
- R1: A call with instruction bit 1 = 1 (legacy form) gives `vec_o` = 0x00C00, `nia_o` = 0xC00 and `save_sel_o` = 0 (pair encoding: 0 = SRR pair, 1 = hypervisor SRR pair, 2 = LR/CTR pair).
- R2: A call with instruction bit 1 = 0 (vectored form) gives `vec_o` = 0x17000 + 32·L, where L = instruction bits 11:5 (`ifield_i`). That is, page 0x17 sits in bits 16:12 above a 12-bit offset. It also gives `save_sel_o` = 2 and `nia_o` = `vec_o` zero-extended, with bits 1:0 forced to 0.
- R3: When `hv_i` is 1, `save_sel_o` = 1 for any call outcome. The hypervisor pair takes priority over the LR/CTR pair.
- R4: Every accepted call raises `intr_o`, `wr_even_o` and `wr_odd_o` for exactly one cycle, in the cycle after `valid_i`.
- R5: On every call, `msr_set_o` has bits 63 (SF) and 0 (LE) set, and `msr_clr_o` has bits 14 (PR), 10 (SE), 9 (BE), 11 (FE0), 8 (FE1), 5 (IR) and 4 (DR) set. Bits 15 (EE) and 1 (RI) are also set in `msr_clr_o` unless the outcome is a vectored call.
- R6: A vectored call with `pr_i` = 1 while the facility bit is 0 instead gives `vec_o` = 0x00F60, `ic_wr_o` = 1 and `ic_o` = 0xC. It is treated as a non-vectored interrupt: pair 0, with EE and RI cleared. With `pr_i` = 0 the facility bit has no effect.
- R7: The facility bit is 1 after reset. It takes the value of `fac_d_i` on the edge where `fac_we_i` is 1, and a call in that same cycle uses the old value.
- R8: A return with `ifield_i[2]` (instruction bit 7) = 1 gives `ret_o` = 1 and `rd_sel_o` = 2. A return with bits 7 and 9 (`ifield_i[4]`) both clear gives `rd_sel_o` = 0. A return with bit 7 clear and bit 9 set gives no `ret_o`.
- R9: On return, `mode_o` = {IR|PR, ~PR, ~LE, ~SF}, taken from `saved_mode_i` = {SF, PR, IR, LE}.
- R10: With `valid_i` = 0, `intr_o`, `ret_o` and `ic_wr_o` are 0 in the following cycle, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction presented this cycle |
| op_call_i | input | 1 | Instruction is a system call |
| op_ret_i | input | 1 | Instruction is a system-call return |
| ibit1_i | input | 1 | Instruction bit 1 (1 = legacy call) |
| ifield_i | input | 7 | Instruction bits 11:5 |
| hv_i | input | 1 | Interrupt is hypervisor class |
| pr_i | input | 1 | Current user-mode (PR) bit |
| saved_mode_i | input | 4 | Saved state bits {SF, PR, IR, LE} for returns |
| fac_we_i | input | 1 | Write strobe for the facility bit |
| fac_d_i | input | 1 | New facility bit value |
| intr_o | output | 1 | One-cycle interrupt entry strobe |
| vec_o | output | 17 | Interrupt vector |
| nia_o | output | 64 | Fetch redirect address |
| save_sel_o | output | 2 | Save pair for entry |
| wr_even_o | output | 1 | Even-bank write enable |
| wr_odd_o | output | 1 | Odd-bank write enable |
| msr_set_o | output | 64 | State bits to set on entry |
| msr_clr_o | output | 64 | State bits to clear on entry |
| ic_wr_o | output | 1 | Write interrupt-cause field |
| ic_o | output | 4 | Interrupt-cause value |
| ret_o | output | 1 | One-cycle return strobe |
| rd_sel_o | output | 2 | Pair to read on return |
| mode_o | output | 4 | Restored {relocate, privileged, big-endian, 32-bit} |

## Verification
The hardest situation to reach from the ports is the facility-unavailable outcome. It needs the internal facility bit first cleared through its write port, and then a vectored call issued from user mode, as two separate steps. The bench also issues a call in the very cycle of a facility write, to show that the old value still applies. It repeats the vectored call with user mode off, to show the bit is ignored there, and then rewrites the bit to 1 and checks that normal vectored entry returns.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int VEC_W   = 17;
  localparam int OFF_W   = 12;
  localparam int LEV_W   = 7;
  localparam int XLEN    = 64;
  localparam int ICW     = 4;

  localparam logic [VEC_W-OFF_W-1:0] SCV_PAGE = 5'h17;
  localparam logic [OFF_W-1:0] LEGACY_OFF = 12'hC00;
  localparam logic [OFF_W-1:0] FACUN_OFF  = 12'hF60;
  localparam logic [ICW-1:0]   FACUN_IC   = 4'hC;

  // state word bit positions
  localparam int B_SF = 63;
  localparam int B_EE = 15;
  localparam int B_PR = 14;
  localparam int B_FE0 = 11;
  localparam int B_SE = 10;
  localparam int B_BE = 9;
  localparam int B_FE1 = 8;
  localparam int B_IR = 5;
  localparam int B_DR = 4;
  localparam int B_RI = 1;
  localparam int B_LE = 0;

  typedef enum logic [1:0] {
    PAIR_SRR   = 2'd0,
    PAIR_HSRR  = 2'd1,
    PAIR_LRCTR = 2'd2
  } pair_e;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    pair_e            pair;
    logic [XLEN-1:0]  set_m;
    logic [XLEN-1:0]  clr_m;
    logic             ic_wr;
    logic             is_scv;
  } entry_t;

  // each vectored entry point is 32 bytes apart inside page 0x17
  function automatic logic [VEC_W-1:0] scv_vector(input logic [LEV_W-1:0] lev);
    return {SCV_PAGE, lev, 5'b00000};
  endfunction

  function automatic logic [XLEN-1:0] fetch_addr(input logic [VEC_W-1:0] v);
    return {{(XLEN-VEC_W){1'b0}}, v[VEC_W-1:2], 2'b00};
  endfunction

  // saved = {SF, PR, IR, LE}; result = {relocate, priv, big-endian, 32-bit}
  function automatic logic [3:0] ret_mode(input logic [3:0] saved);
    return {saved[1] | saved[2], ~saved[2], ~saved[0], ~saved[3]};
  endfunction
endpackage

// File: rtl/sc_fac_reg.sv
module sc_fac_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q_o <= 1'b1;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/sc_entry.sv
module sc_entry
  import sc_pkg::*;
(
  input  logic             legacy_i,
  input  logic [LEV_W-1:0] lev_i,
  input  logic             hv_i,
  input  logic             pr_i,
  input  logic             fac_i,
  output entry_t           ent_o
);
  logic fac_block;
  assign fac_block = !legacy_i && pr_i && !fac_i;

  logic [XLEN-1:0] base_clr;
  always_comb begin
    base_clr = '0;
    base_clr[B_PR]  = 1'b1;
    base_clr[B_SE]  = 1'b1;
    base_clr[B_BE]  = 1'b1;
    base_clr[B_FE0] = 1'b1;
    base_clr[B_FE1] = 1'b1;
    base_clr[B_IR]  = 1'b1;
    base_clr[B_DR]  = 1'b1;
  end

  always_comb begin
    ent_o        = '0;
    ent_o.is_scv = !legacy_i && !fac_block;
    ent_o.ic_wr  = fac_block;
    if (legacy_i)       ent_o.vec = {5'h00, LEGACY_OFF};
    else if (fac_block) ent_o.vec = {5'h00, FACUN_OFF};
    else                ent_o.vec = scv_vector(lev_i);

    if (hv_i)              ent_o.pair = PAIR_HSRR;
    else if (ent_o.is_scv) ent_o.pair = PAIR_LRCTR;
    else                   ent_o.pair = PAIR_SRR;

    ent_o.set_m       = '0;
    ent_o.set_m[B_SF] = 1'b1;
    ent_o.set_m[B_LE] = 1'b1;
    ent_o.clr_m       = base_clr;
    if (!ent_o.is_scv) begin
      ent_o.clr_m[B_EE] = 1'b1;
      ent_o.clr_m[B_RI] = 1'b1;
    end
  end
endmodule

// File: rtl/sc_return.sv
module sc_return
  import sc_pkg::*;
(
  input  logic       b7_i,
  input  logic       b9_i,
  input  logic [3:0] saved_i,
  output logic       take_o,
  output pair_e      pair_o,
  output logic [3:0] mode_o
);
  always_comb begin
    take_o = b7_i || !b9_i;
    pair_o = b7_i ? PAIR_LRCTR : PAIR_SRR;
    mode_o = ret_mode(saved_i);
  end
endmodule

// File: rtl/syscall_ctl.sv
module syscall_ctl
  import sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              op_call_i,
  input  logic              op_ret_i,
  input  logic              ibit1_i,
  input  logic [LEV_W-1:0]  ifield_i,
  input  logic              hv_i,
  input  logic              pr_i,
  input  logic [3:0]        saved_mode_i,
  input  logic              fac_we_i,
  input  logic              fac_d_i,
  output logic              intr_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [XLEN-1:0]   nia_o,
  output logic [1:0]        save_sel_o,
  output logic              wr_even_o,
  output logic              wr_odd_o,
  output logic [XLEN-1:0]   msr_set_o,
  output logic [XLEN-1:0]   msr_clr_o,
  output logic              ic_wr_o,
  output logic [ICW-1:0]    ic_o,
  output logic              ret_o,
  output logic [1:0]        rd_sel_o,
  output logic [3:0]        mode_o
);
  logic fac_q;
  sc_fac_reg u_fac (
    .clk(clk), .rst_n(rst_n), .we_i(fac_we_i), .d_i(fac_d_i), .q_o(fac_q)
  );

  entry_t ent;
  sc_entry u_ent (
    .legacy_i(ibit1_i), .lev_i(ifield_i), .hv_i(hv_i), .pr_i(pr_i),
    .fac_i(fac_q), .ent_o(ent)
  );

  logic       ret_take;
  pair_e      ret_pair;
  logic [3:0] ret_mode_w;
  sc_return u_ret (
    .b7_i(ifield_i[2]), .b9_i(ifield_i[4]), .saved_i(saved_mode_i),
    .take_o(ret_take), .pair_o(ret_pair), .mode_o(ret_mode_w)
  );

  // named events for assertions
  logic call_go, ret_go;
  assign call_go = valid_i && op_call_i;
  assign ret_go  = valid_i && op_ret_i && !op_call_i && ret_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intr_o     <= 1'b0;
      vec_o      <= '0;
      nia_o      <= '0;
      save_sel_o <= '0;
      wr_even_o  <= 1'b0;
      wr_odd_o   <= 1'b0;
      msr_set_o  <= '0;
      msr_clr_o  <= '0;
      ic_wr_o    <= 1'b0;
      ic_o       <= '0;
      ret_o      <= 1'b0;
      rd_sel_o   <= '0;
      mode_o     <= '0;
    end else begin
      intr_o    <= call_go;
      wr_even_o <= call_go;
      wr_odd_o  <= call_go;
      ic_wr_o   <= call_go && ent.ic_wr;
      ret_o     <= ret_go;
      if (call_go) begin
        vec_o      <= ent.vec;
        nia_o      <= fetch_addr(ent.vec);
        save_sel_o <= ent.pair;
        msr_set_o  <= ent.set_m;
        msr_clr_o  <= ent.clr_m;
        ic_o       <= ent.ic_wr ? FACUN_IC : '0;
      end
      if (ret_go) begin
        rd_sel_o <= ret_pair;
        mode_o   <= ret_mode_w;
      end
    end
  end

  // R4: strobe comes only from an accepted call in the previous cycle
  a_r4_strobe_from_call: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o |-> $past(valid_i && op_call_i));
  // R4: both banks written together with the strobe
  a_r4_both_banks: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o |-> (wr_even_o && wr_odd_o));
  // R2: LR/CTR saves always land in page 0x17 unless hypervisor
  a_r2_scv_page: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_o && save_sel_o == PAIR_LRCTR) |-> vec_o[VEC_W-1:OFF_W] == SCV_PAGE);
  // R6: cause write only with the facility vector
  a_r6_facun_vec: assert property (@(posedge clk) disable iff (!rst_n)
    ic_wr_o |-> (intr_o && vec_o == {5'h00, FACUN_OFF} && ic_o == FACUN_IC));
  // R10: nothing happens after an idle cycle
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(valid_i) |-> (!intr_o && !ret_o && !ic_wr_o));
  // R5: vectored entry leaves EE and RI alone
  a_r5_scv_keeps_ee: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_o && save_sel_o == PAIR_LRCTR) |-> !msr_clr_o[B_EE] && !msr_clr_o[B_RI]);
  // R8: return reading LR/CTR only after bit 7 was set
  a_r8_ret_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_o && rd_sel_o == PAIR_LRCTR) |-> $past(ifield_i[2]));
endmodule

// File: tb/tb_syscall_ctl.sv
module tb_syscall_ctl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, valid_i, op_call_i, op_ret_i, ibit1_i, hv_i, pr_i, fac_we_i, fac_d_i;
  logic [6:0] ifield_i;
  logic [3:0] saved_mode_i;
  logic intr_o, wr_even_o, wr_odd_o, ic_wr_o, ret_o;
  logic [16:0] vec_o;
  logic [63:0] nia_o, msr_set_o, msr_clr_o;
  logic [1:0] save_sel_o, rd_sel_o;
  logic [3:0] ic_o, mode_o;

  syscall_ctl dut (.*);

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_clr(input bit scv);
    logic [63:0] m;
    m = 64'b0;
    m[14] = 1; m[10] = 1; m[9] = 1; m[11] = 1; m[8] = 1; m[5] = 1; m[4] = 1;
    if (!scv) begin m[15] = 1; m[1] = 1; end
    return m;
  endfunction

  localparam logic [63:0] SETM = 64'h8000_0000_0000_0001;

  task automatic idle_inputs();
    valid_i = 0; op_call_i = 0; op_ret_i = 0; ibit1_i = 0; hv_i = 0; pr_i = 0;
    fac_we_i = 0; fac_d_i = 0; ifield_i = 0; saved_mode_i = 0;
  endtask

  // drive a call at a negedge, return at the next negedge with outputs valid
  task automatic do_call(input bit legacy, input logic [6:0] lev, input bit hv, input bit pr);
    valid_i = 1; op_call_i = 1; ibit1_i = legacy; ifield_i = lev; hv_i = hv; pr_i = pr;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    chk("R4 reset intr", intr_o, 0);
    chk("R8 reset ret", ret_o, 0);
    chk("R6 reset icwr", ic_wr_o, 0);
  endtask

  task automatic t_legacy();
    do_call(1, 7'h33, 0, 1);
    chk("R1 vec", vec_o, 17'h00C00);
    chk("R1 nia", nia_o, 64'hC00);
    chk("R1 sel", save_sel_o, 0);
    chk("R4 intr", intr_o, 1);
    chk("R4 wr banks", {wr_even_o, wr_odd_o}, 2'b11);
    chk("R5 set", msr_set_o, SETM);
    chk("R5 clr legacy", msr_clr_o, exp_clr(0));
    @(negedge clk);
    chk("R4 one cycle", {intr_o, wr_even_o, wr_odd_o}, 0);
  endtask

  task automatic t_vectored();
    logic [6:0] levs [3];
    levs[0] = 7'd0; levs[1] = 7'd127; levs[2] = 7'h55;
    foreach (levs[i]) begin
      logic [63:0] e;
      e = 64'h17000 + 64'(levs[i]) * 32;
      do_call(0, levs[i], 0, 1);
      chk("R2 vec", vec_o, e);
      chk("R2 nia", nia_o, e);
      chk("R2 sel", save_sel_o, 2);
      chk("R5 clr scv", msr_clr_o, exp_clr(1));
      chk("R5 set scv", msr_set_o, SETM);
    end
  endtask

  task automatic t_hv();
    do_call(0, 7'd3, 1, 0);
    chk("R3 hv over scv", save_sel_o, 1);
    chk("R3 hv vec", vec_o, 64'h17000 + 3 * 32);
    do_call(1, 7'd0, 1, 0);
    chk("R3 hv legacy", save_sel_o, 1);
  endtask

  task automatic t_fac();
    // write 0 and issue a call in the same cycle: old value 1 used
    fac_we_i = 1; fac_d_i = 0;
    do_call(0, 7'd9, 0, 1);
    chk("R7 same-cycle old value", vec_o, 64'h17000 + 9 * 32);
    chk("R7 no cause", ic_wr_o, 0);
    do_call(0, 7'd9, 0, 1);
    chk("R6 facun vec", vec_o, 17'h00F60);
    chk("R6 cause wr", ic_wr_o, 1);
    chk("R6 cause", ic_o, 4'hC);
    chk("R6 sel", save_sel_o, 0);
    chk("R6 clr", msr_clr_o, exp_clr(0));
    do_call(0, 7'd9, 0, 0);
    chk("R6 supervisor ignores bit", vec_o, 64'h17000 + 9 * 32);
    chk("R6 supervisor no cause", ic_wr_o, 0);
    fac_we_i = 1; fac_d_i = 1;
    @(negedge clk);
    idle_inputs();
    do_call(0, 7'd1, 0, 1);
    chk("R7 rewritten", vec_o, 64'h17000 + 32);
  endtask

  task automatic t_return();
    // bit 7 set: LR/CTR; saved {SF,PR,IR,LE} = 0100 -> {1,0,1,1}
    valid_i = 1; op_ret_i = 1; ifield_i = 7'b0000100; saved_mode_i = 4'b0100;
    @(negedge clk); idle_inputs();
    chk("R8 ret strobe", ret_o, 1);
    chk("R8 ret lrctr", rd_sel_o, 2);
    chk("R9 mode a", mode_o, 4'b1011);
    chk("R8 no intr", intr_o, 0);
    // ordinary return; saved = 1011 -> {1,1,0,0}
    valid_i = 1; op_ret_i = 1; ifield_i = 7'b0000000; saved_mode_i = 4'b1011;
    @(negedge clk); idle_inputs();
    chk("R8 ret srr", rd_sel_o, 0);
    chk("R9 mode b", mode_o, 4'b1100);
    // bit 9 set, bit 7 clear: ignored, previous outputs held
    valid_i = 1; op_ret_i = 1; ifield_i = 7'b0010000; saved_mode_i = 4'b0000;
    @(negedge clk); idle_inputs();
    chk("R8 hv return ignored", ret_o, 0);
    chk("R8 hv return mode held", mode_o, 4'b1100);
  endtask

  task automatic t_idle();
    op_call_i = 1; op_ret_i = 0; ibit1_i = 1; valid_i = 0;
    @(negedge clk);
    chk("R10 no intr", intr_o, 0);
    op_call_i = 0; op_ret_i = 1; ifield_i = 7'b0000100;
    @(negedge clk);
    chk("R10 no ret", ret_o, 0);
    chk("R10 no cause", ic_wr_o, 0);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_legacy();
    t_vectored();
    t_hv();
    t_fac();
    t_return();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule